// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block decides which 5-bit frequency selection code a clock generator runs with. While the supply ramps, four dual-purpose pins are read as configuration straps. The board pulls these pins low when they are left open, so an open strap reads as 0. A settle counter starts when the power-good input rises. When it expires, the block captures the four strap values in the same clock edge and raises an output enable, so that the pins turn into clock outputs from then on.

A control byte written by software can replace the captured hardware selection with a selection of its own. The five software bits sit in the byte in a non-contiguous order. The same byte also carries the spread-spectrum enable and the test-mode select. Every change of the active code is reported with a one-cycle flag and a smooth/abrupt qualifier. A change is smooth when the old and new codes belong to the same switching group. A change across groups is abrupt, which means the output frequency jumps at once.

Top module: `freq_sel_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, `strap_oe` is 0, `sel_chg` is 0 and `chg_smooth` is 0. With hardware selection and no straps captured yet, `sel_code` is 0.
- R2: `strap_oe` rises on the SETTLE_CYCLES-th consecutive rising clock edge at which `pwr_good` is high. If `pwr_good` goes low before that edge, the count restarts from zero. Once `strap_oe` is high it stays high until reset.
- R3: The strap values are captured on the clock edge that raises `strap_oe`. Any strap change after that edge has no effect on `sel_code`. The bits of `strap_in` are ordered [3]=S3, [2]=S2, [1]=S1, [0]=S0.
- R4: When `ctrl_byte[3]` is 0 (hardware selection), `sel_code` = {1'b0, S3, S2, S1, S0} taken from the captured straps. Bits 7, 6, 5, 4 and 2 of `ctrl_byte` then have no effect on `sel_code`.
- R5: When `ctrl_byte[3]` is 1 (software selection), `sel_code[4:0]` = {`ctrl_byte[7]`, `ctrl_byte[2]`, `ctrl_byte[6]`, `ctrl_byte[5]`, `ctrl_byte[4]`}. This gives code bit 4..0 = S4, S3, S2, S1, S0.
- R6: `spread_en` follows `ctrl_byte[1]` and `test_mode` follows `ctrl_byte[0]` (1 = test, 0 = normal running), whichever selection source is active.
- R7: `sel_chg` is high for exactly the one cycle after a clock edge at which `sel_code` differs from its value at the previous edge. The first edge after reset compares against code 0.
- R8: `chg_smooth` is high together with `sel_chg` exactly when the old and new codes share a group, and it is 0 whenever `sel_chg` is 0. Group two is the code set {00000, 00011, 00110, 01010, 10000, 10101}. Group three is the code set {00100, 00101, 01000, 01001, 01011, 01100, 01110, 01111, 10011, 10100, 10110, 11000, 11001}.
- R9: Every code outside the two listed sets belongs to group one, so a change between two such codes is smooth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply settled indication; starts the settle count |
| strap_in | input | 4 | Strap pin levels read while the pins are inputs ([3]=S3 .. [0]=S0) |
| ctrl_byte | input | 8 | Software control byte: selection bits, source select, spread, test |
| sel_code | output | 5 | Active frequency selection code |
| strap_oe | output | 1 | Turns the strap pins into clock outputs |
| spread_en | output | 1 | Spread-spectrum enable |
| test_mode | output | 1 | Test mode select |
| sel_chg | output | 1 | One-cycle pulse after the active code changes |
| chg_smooth | output | 1 | Qualifies `sel_chg`: 1 = same group (smooth), 0 = abrupt |

## Verification
The bench builds the block with SETTLE_CYCLES = 5. This short count makes it cheap to reset and walk the full settle sequence for each of the 16 strap patterns, including a power-good drop partway through the count. The same build then sweeps all 256 control-byte values in both selection modes. It also steps through all 1024 ordered pairs of selection codes, so every group boundary, every same-group change and every no-change case is checked against group sets held as bit masks in the bench.

// File: rtl/freqsel_pkg.sv
// Shared types and the switching-group lookup for the frequency select controller.
package freqsel_pkg;

    localparam int CODE_W = 5;
    localparam int STRAP_W = 4;

    typedef logic [CODE_W-1:0] sel_code_t;

    typedef enum logic [1:0] {
        GRP_ONE   = 2'd1,
        GRP_TWO   = 2'd2,
        GRP_THREE = 2'd3
    } sw_group_t;

    // Map a selection code to its smooth-switching group; unlisted codes are group one.
    function automatic sw_group_t group_of(input sel_code_t code);
        sw_group_t g;
        case (code)
            5'b00000, 5'b00011, 5'b00110, 5'b01010, 5'b10000, 5'b10101:
                g = GRP_TWO;
            5'b00100, 5'b00101, 5'b01000, 5'b01001, 5'b01011, 5'b01100,
            5'b01110, 5'b01111, 5'b10011, 5'b10100, 5'b10110, 5'b11000,
            5'b11001:
                g = GRP_THREE;
            default:
                g = GRP_ONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/fs_settle.sv
// Settle timer and strap capture.
// Counts consecutive cycles with pwr_good high. On the SETTLE_CYCLES-th such edge it
// captures the strap levels and raises the pin output enable, which then holds until reset.
// Assumes the strap pins carry stable levels as seen by the clock domain (synchronised upstream).
module fs_settle #(
    parameter int SETTLE_CYCLES = 1000,
    parameter int STRAP_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               settled
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = pwr_good && !settled && (cnt == LAST);

    // Count cycles of steady power-good; restart on a drop, freeze once settled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (settled || !pwr_good) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Capture the straps and raise the output enable on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settled <= 1'b0;
            strap_q <= '0;
        end else if (expire) begin
            settled <= 1'b1;
            strap_q <= strap_in;
        end
    end

endmodule

// File: rtl/fs_source.sv
// Selection source multiplexer.
// Chooses between the captured hardware straps (S4 forced low) and the software bits
// of the control byte, unscrambling the software bit order into code order S4..S0.
module fs_source
    import freqsel_pkg::*;
(
    input  logic [STRAP_W-1:0] strap_q,
    input  logic [7:0]         ctrl_byte,
    output sel_code_t          sel_code,
    output logic               spread_en,
    output logic               test_mode
);
    localparam int SRC_BIT = 3;

    sel_code_t hw_code;
    sel_code_t sw_code;

    // Build both candidate codes and pick one by the source bit.
    always_comb begin
        hw_code  = {1'b0, strap_q};
        sw_code  = {ctrl_byte[7], ctrl_byte[2], ctrl_byte[6], ctrl_byte[5], ctrl_byte[4]};
        sel_code = ctrl_byte[SRC_BIT] ? sw_code : hw_code;
    end

    assign spread_en = ctrl_byte[1];
    assign test_mode = ctrl_byte[0];

endmodule

// File: rtl/fs_classify.sv
// Change classifier.
// Remembers the code seen at the previous edge; on a difference it pulses a change flag
// and reports whether both codes fall in the same switching group. Reset history is code 0.
module fs_classify
    import freqsel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sel_code_t sel_code,
    output logic      sel_chg,
    output logic      chg_smooth
);
    sel_code_t prev_code;
    logic      differ;
    logic      same_grp;

    // Compare the new code with the remembered one and look up both groups.
    always_comb begin
        differ   = (sel_code != prev_code);
        same_grp = (group_of(sel_code) == group_of(prev_code));
    end

    // Register the history and the change report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_code  <= '0;
            sel_chg    <= 1'b0;
            chg_smooth <= 1'b0;
        end else begin
            prev_code  <= sel_code;
            sel_chg    <= differ;
            chg_smooth <= differ && same_grp;
        end
    end

endmodule

// File: rtl/freq_sel_ctrl.sv
// Strap-latched frequency select controller (top).
// Ties the settle timer, the source multiplexer and the change classifier together.
// Assumes a synchronous active-low reset held for at least one clock at start-up.
module freq_sel_ctrl
    import freqsel_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic [3:0] strap_in,
    input  logic [7:0] ctrl_byte,
    output logic [4:0] sel_code,
    output logic       strap_oe,
    output logic       spread_en,
    output logic       test_mode,
    output logic       sel_chg,
    output logic       chg_smooth
);
    logic [STRAP_W-1:0] strap_q;

    fs_settle #(
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .STRAP_W      (STRAP_W)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_good(pwr_good),
        .strap_in(strap_in),
        .strap_q (strap_q),
        .settled (strap_oe)
    );

    fs_source u_source (
        .strap_q  (strap_q),
        .ctrl_byte(ctrl_byte),
        .sel_code (sel_code),
        .spread_en(spread_en),
        .test_mode(test_mode)
    );

    fs_classify u_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_code  (sel_code),
        .sel_chg   (sel_chg),
        .chg_smooth(chg_smooth)
    );

endmodule

// File: rtl/fs_chk.sv
// Property checker for freq_sel_ctrl, attached through bind.
// Assumes reset is asserted at the first clock edge.
module fs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic [7:0] ctrl_byte,
    input logic [4:0] sel_code,
    input logic       strap_oe,
    input logic       sel_chg,
    input logic       chg_smooth
);
    logic armed;

    // Mark the cycles after the first edge out of reset, so that history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_oe |=> strap_oe);

    // R2
    oe_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good && !strap_oe) |=> !strap_oe);

    // R3
    hw_code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && strap_oe && $past(strap_oe) && !ctrl_byte[3] && !$past(ctrl_byte[3]))
        |-> $stable(sel_code));

    // R7
    change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (sel_code != $past(sel_code))) |=> sel_chg);

    // R7
    quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (sel_code == $past(sel_code))) |=> !sel_chg);

    // R8
    smooth_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_smooth |-> sel_chg);

endmodule

bind freq_sel_ctrl fs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .ctrl_byte (ctrl_byte),
    .sel_code  (sel_code),
    .strap_oe  (strap_oe),
    .sel_chg   (sel_chg),
    .chg_smooth(chg_smooth)
);

// File: tb/sim_freq_sel_ctrl.sv
// Bench: settle/strap sweep, control-byte sweep and all code-pair transitions.
module sim_freq_sel_ctrl;
    localparam int SETTLE = 5;
    localparam logic [31:0] G2_MASK = 32'h0021_0449;
    localparam logic [31:0] G3_MASK = 32'h0358_DB30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic [3:0] strap_in = '0;
    logic [7:0] ctrl_byte = '0;
    logic [4:0] sel_code;
    logic       strap_oe, spread_en, test_mode, sel_chg, chg_smooth;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    freq_sel_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_in(strap_in),
        .ctrl_byte(ctrl_byte), .sel_code(sel_code), .strap_oe(strap_oe),
        .spread_en(spread_en), .test_mode(test_mode), .sel_chg(sel_chg),
        .chg_smooth(chg_smooth)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int grp(input logic [4:0] c);
        if (G2_MASK[c]) return 2;
        if (G3_MASK[c]) return 3;
        return 1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwr_good = 1'b0; ctrl_byte = '0; strap_in = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 oe", {7'b0, strap_oe}, 8'd0);
        chk("R1 code", {3'b0, sel_code}, 8'd0);
        chk("R1 chg", {6'b0, sel_chg, chg_smooth}, 8'd0);

        // R2 interrupted power-good restarts the count
        pwr_good = 1'b1;
        repeat (SETTLE - 2) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        chk("R2 drop oe", {7'b0, strap_oe}, 8'd0);
        pwr_good = 1'b1;
        repeat (SETTLE - 1) @(negedge clk);
        chk("R2 restart early", {7'b0, strap_oe}, 8'd0);
        @(negedge clk);
        chk("R2 restart expiry", {7'b0, strap_oe}, 8'd1);
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 sticky", {7'b0, strap_oe}, 8'd1);

        // R2/R3/R4 sweep of all strap patterns
        for (int s = 0; s < 16; s++) begin
            do_reset();
            strap_in = 4'(~s);
            pwr_good = 1'b1;
            repeat (SETTLE - 1) @(negedge clk);
            chk("R2 not yet", {7'b0, strap_oe}, 8'd0);
            strap_in = 4'(s);
            @(negedge clk);
            chk("R2 expiry", {7'b0, strap_oe}, 8'd1);
            chk("R3 capture", {3'b0, sel_code}, 8'(s));
            strap_in = 4'(~s);
            @(negedge clk);
            chk("R3 later strap ignored", {3'b0, sel_code}, 8'(s));
            ctrl_byte = 8'b1111_0111;
            #1;
            chk("R4 hw ignores sw bits", {3'b0, sel_code}, 8'(s));
            ctrl_byte = '0;
        end

        // R5/R6/R4 sweep of every control byte (straps captured = 4'hA)
        do_reset();
        strap_in = 4'hA;
        pwr_good = 1'b1;
        repeat (SETTLE) @(negedge clk);
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            logic [4:0] e;
            v = 8'(b);
            ctrl_byte = v;
            #1;
            e = v[3] ? {v[7], v[2], v[6], v[5], v[4]} : 5'h0A;
            chk(v[3] ? "R5 sw map" : "R4 hw map", {3'b0, sel_code}, {3'b0, e});
            chk("R6 spread/test", {6'b0, spread_en, test_mode}, {6'b0, v[1], v[0]});
        end

        // R7/R8/R9 all ordered code pairs in software mode
        for (int a = 0; a < 32; a++) begin
            for (int c = 0; c < 32; c++) begin
                logic [4:0] ca, cc;
                logic       en, es;
                ca = 5'(a);
                cc = 5'(c);
                @(negedge clk);
                ctrl_byte = {ca[4], ca[2], ca[1], ca[0], 1'b1, ca[3], 2'b00};
                @(negedge clk);
                @(negedge clk);
                chk("R7 settled quiet", {7'b0, sel_chg}, 8'd0);
                ctrl_byte = {cc[4], cc[2], cc[1], cc[0], 1'b1, cc[3], 2'b00};
                @(negedge clk);
                en = (ca != cc);
                es = en && (grp(ca) == grp(cc));
                chk("R7 change flag", {7'b0, sel_chg}, {7'b0, en});
                if (grp(ca) == 1 && grp(cc) == 1)
                    chk("R9 group one smooth", {7'b0, chg_smooth}, {7'b0, es});
                else
                    chk("R8 group smooth", {7'b0, chg_smooth}, {7'b0, es});
                @(negedge clk);
                chk("R7 single pulse", {7'b0, sel_chg}, 8'd0);
            end
        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule